// File: doc/BRIEF.md
# Aliased Partial-Width Register File

This block holds eight 32-bit general registers and lets each one be reached through three overlapping views: the full 32-bit value, its low 16-bit half, or a single byte. The byte view can reach either the low byte or the second byte of the first four registers only. A narrow write merges its bits into the register and leaves the other bits as they were. The other four registers have no byte view at all, so no byte access can reach them.

One write port takes a register index, a view code and data. Two independent read ports each take an index and a view code and return the selected view, zero-extended to 32 bits, with no clock delay. An undefined view code on the write port blocks the write and raises a one-cycle error pulse. On a read port it returns zero. All ports are plain control and data pins with no valid/ready handshake. A write is accepted every cycle that `wr_en` is high and can never be held off, and a read port always shows the view its inputs select.

Top module: `aliased_regfile`

## Requirements
- R1: Register index codes are 0=A, 1=C, 2=D, 3=B, 4=SP, 5=BP, 6=SI, 7=DI. View code 2 (dword) writes and reads all 32 bits of the indexed register.
- R2: A write with view code 1 (word) replaces bits 15:0 of the indexed register and keeps bits 31:16.
- R3: A write with view code 0 (byte) and index 0 to 3 replaces bits 7:0 of register A, C, D or B in that order and keeps every other bit.
- R4: A byte-view access with index 4 to 7 reaches bits 15:8 of A, C, D or B in that order. A byte access never reaches SP, BP, SI or DI and raises no error.
- R5: Each read port returns the view its index and view code select, zero-extended to 32 bits. The two ports work independently.
- R6: A read returns the register contents from before the clock edge. A write shows on a read only after the edge that stores it.
- R7: A write with view code 3 changes no register. `wr_err` is high in the cycle after each such write and low otherwise.
- R8: A read with view code 3 returns zero.
- R9: A synchronous active-high reset clears every register and `wr_err`.
- R10: With `wr_en` low, no register changes, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register index |
| wr_width | input | 2 | Write view code: 0 byte, 1 word, 2 dword, 3 undefined |
| wr_data | input | 32 | Write data, right-aligned for narrow views |
| wr_err | output | 1 | One-cycle pulse after a write with an undefined view |
| rda_idx | input | 3 | Read port A register index |
| rda_width | input | 2 | Read port A view code |
| rda_data | output | 32 | Read port A data, zero-extended |
| rdb_idx | input | 3 | Read port B register index |
| rdb_width | input | 2 | Read port B view code |
| rdb_data | output | 32 | Read port B data, zero-extended |

## Verification
The assertions check these rules on every cycle: zero-extension of narrow reads, zero on an undefined read view, the pairing of each undefined write with its error pulse, that such a write leaves a steady read unchanged, that word writes keep the upper half, that both ports agree when they select the same view, and that the register file is clear after reset. The bench's scenarios are what show the byte-index aliasing: the high byte of A, C, D and B reached through indices 4 to 7, and byte writes that never touch SP, BP, SI or DI. The scenarios also show the read-before-write timing within a cycle and the effect of a disabled write.

// File: rtl/aprf_pkg.sv
package aprf_pkg;
  typedef enum logic [1:0] {
    VW_BYTE  = 2'd0,
    VW_WORD  = 2'd1,
    VW_DWORD = 2'd2,
    VW_BAD   = 2'd3
  } view_e;
endpackage

// File: rtl/view_decode.sv
module view_decode
  import aprf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREGS  = 8
) (
  input  logic [$clog2(NREGS)-1:0]  idx,
  input  logic [1:0]                width,
  output logic [$clog2(NREGS)-1:0]  phys,
  output logic [$clog2(DATA_W)-1:0] sh,
  output logic [DATA_W-1:0]         mask,
  output logic                      legal
);
  localparam int IDX_W  = $clog2(NREGS);
  localparam int SH_W   = $clog2(DATA_W);
  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = 8;
  localparam int SPLIT  = NREGS / 2;
  localparam logic [DATA_W-1:0] HALF_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  view_e vw;
  assign vw = view_e'(width);

  always_comb begin
    phys  = idx;
    sh    = '0;
    mask  = '0;
    legal = 1'b1;
    unique case (vw)
      VW_DWORD: mask = '1;
      VW_WORD:  mask = HALF_MASK;
      VW_BYTE: begin
        // upper half of the index space aliases the second byte of the split registers
        phys = idx & IDX_W'(SPLIT - 1);
        sh   = idx[IDX_W-1] ? SH_W'(BYTE_W) : '0;
        mask = BYTE_MASK << sh;
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpr_array.sv
module gpr_array #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wen,
  input  logic [$clog2(NREGS)-1:0]       wsel,
  input  logic [DATA_W-1:0]              wmask,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NREGS-1:0][DATA_W-1:0]   q
);
  localparam int IDX_W = $clog2(NREGS);

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        q[g] <= '0;
      else if (wen && wsel == IDX_W'(g))
        q[g] <= (q[g] & ~wmask) | (wdata & wmask);
    end
  end
endmodule

// File: rtl/read_view.sv
module read_view #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 8
) (
  input  logic [NREGS-1:0][DATA_W-1:0] regs,
  input  logic [$clog2(NREGS)-1:0]     idx,
  input  logic [1:0]                   width,
  output logic [DATA_W-1:0]            data
);
  localparam int IDX_W = $clog2(NREGS);
  localparam int SH_W  = $clog2(DATA_W);

  logic [IDX_W-1:0]  phys;
  logic [SH_W-1:0]   sh;
  logic [DATA_W-1:0] mask;
  logic              legal;

  view_decode #(.DATA_W(DATA_W), .NREGS(NREGS)) u_dec (
    .idx(idx), .width(width), .phys(phys), .sh(sh), .mask(mask), .legal(legal)
  );

  assign data = legal ? ((regs[phys] & mask) >> sh) : '0;
endmodule

// File: rtl/aliased_regfile.sv
module aliased_regfile #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [$clog2(NREGS)-1:0]   wr_idx,
  input  logic [1:0]                 wr_width,
  input  logic [DATA_W-1:0]          wr_data,
  output logic                       wr_err,
  input  logic [$clog2(NREGS)-1:0]   rda_idx,
  input  logic [1:0]                 rda_width,
  output logic [DATA_W-1:0]          rda_data,
  input  logic [$clog2(NREGS)-1:0]   rdb_idx,
  input  logic [1:0]                 rdb_width,
  output logic [DATA_W-1:0]          rdb_data
);
  localparam int IDX_W = $clog2(NREGS);
  localparam int SH_W  = $clog2(DATA_W);

  logic [IDX_W-1:0]              w_phys;
  logic [SH_W-1:0]               w_sh;
  logic [DATA_W-1:0]             w_mask;
  logic                          w_legal;
  logic [NREGS-1:0][DATA_W-1:0]  regs;

  view_decode #(.DATA_W(DATA_W), .NREGS(NREGS)) u_wdec (
    .idx(wr_idx), .width(wr_width), .phys(w_phys), .sh(w_sh), .mask(w_mask), .legal(w_legal)
  );

  gpr_array #(.DATA_W(DATA_W), .NREGS(NREGS)) u_gpr (
    .clk(clk), .rst(rst), .wen(wr_en && w_legal), .wsel(w_phys),
    .wmask(w_mask), .wdata(wr_data << w_sh), .q(regs)
  );

  read_view #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rda (
    .regs(regs), .idx(rda_idx), .width(rda_width), .data(rda_data)
  );

  read_view #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rdb (
    .regs(regs), .idx(rdb_idx), .width(rdb_width), .data(rdb_data)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_err <= 1'b0;
    else     wr_err <= wr_en && !w_legal;
  end
endmodule

// File: rtl/aliased_regfile_chk.sv
module aliased_regfile_chk #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic [$clog2(NREGS)-1:0] wr_idx,
  input logic [1:0]               wr_width,
  input logic [DATA_W-1:0]        wr_data,
  input logic                     wr_err,
  input logic [$clog2(NREGS)-1:0] rda_idx,
  input logic [1:0]               rda_width,
  input logic [DATA_W-1:0]        rda_data,
  input logic [$clog2(NREGS)-1:0] rdb_idx,
  input logic [1:0]               rdb_width,
  input logic [DATA_W-1:0]        rdb_data
);
  localparam int HALF_W = DATA_W / 2;

  AST_WORD_WRITE_KEEPS_TOP: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && wr_width == 2'd1 && rda_idx == wr_idx && rda_width == 2'd2)
      && !$past(rst) && $stable(rda_idx) && $stable(rda_width))
    |-> (rda_data[DATA_W-1:HALF_W] == $past(rda_data[DATA_W-1:HALF_W])
      && rda_data[HALF_W-1:0] == $past(wr_data[HALF_W-1:0]))); // R2

  AST_ZEXT_WORD: assert property (@(posedge clk) disable iff (rst)
    rda_width == 2'd1 |-> rda_data[DATA_W-1:HALF_W] == '0); // R5

  AST_ZEXT_BYTE: assert property (@(posedge clk) disable iff (rst)
    rdb_width == 2'd0 |-> rdb_data[DATA_W-1:8] == '0); // R5

  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
    (rda_idx == rdb_idx && rda_width == rdb_width) |-> rda_data == rdb_data); // R5

  AST_BAD_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_width == 2'd3) |=> wr_err); // R7

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(wr_en && wr_width == 2'd3)); // R7

  AST_BAD_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && wr_width == 2'd3) && $stable(rda_idx) && $stable(rda_width))
    |-> $stable(rda_data)); // R7

  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    rda_width == 2'd3 |-> rda_data == '0); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rda_data == '0 && rdb_data == '0 && !wr_err)); // R9
endmodule

bind aliased_regfile aliased_regfile_chk #(.DATA_W(DATA_W), .NREGS(NREGS)) u_chk (.*);

// File: tb/aliased_regfile_test.sv
module aliased_regfile_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [1:0]  wr_width = '0;
  logic [31:0] wr_data = '0;
  logic        wr_err;
  logic [2:0]  rda_idx = '0;
  logic [1:0]  rda_width = 2'd2;
  logic [31:0] rda_data;
  logic [2:0]  rdb_idx = '0;
  logic [1:0]  rdb_width = 2'd2;
  logic [31:0] rdb_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  aliased_regfile uut (.*);

  // {wr_en, wr_idx, wr_width, wr_data, rd_idx, rd_width, expected, req}
  localparam int NV = 16;
  localparam logic [78:0] VEC [NV] = '{
    {1'b1, 3'd0, 2'd2, 32'h11223344, 3'd0, 2'd2, 32'h11223344, 4'd1},  // R1 dword A
    {1'b1, 3'd0, 2'd1, 32'hAAAA5555, 3'd0, 2'd2, 32'h11225555, 4'd2},  // R2 word keeps top
    {1'b1, 3'd0, 2'd0, 32'h000000EE, 3'd0, 2'd2, 32'h112255EE, 4'd3},  // R3 low byte A
    {1'b1, 3'd4, 2'd0, 32'h000000CC, 3'd0, 2'd2, 32'h1122CCEE, 4'd4},  // R4 high byte A
    {1'b0, 3'd0, 2'd2, 32'h00000000, 3'd4, 2'd0, 32'h000000CC, 4'd5},  // R5 byte read
    {1'b0, 3'd0, 2'd2, 32'h00000000, 3'd0, 2'd1, 32'h0000CCEE, 4'd5},  // R5 word read
    {1'b1, 3'd3, 2'd2, 32'hDEADBEEF, 3'd7, 2'd0, 32'h000000BE, 4'd4},  // R4 high byte B read
    {1'b1, 3'd7, 2'd0, 32'h12345677, 3'd3, 2'd2, 32'hDEAD77EF, 4'd4},  // R4 high byte B write
    {1'b1, 3'd4, 2'd2, 32'hCAFEF00D, 3'd4, 2'd2, 32'hCAFEF00D, 4'd1},  // R1 dword SP
    {1'b1, 3'd0, 2'd0, 32'h00000099, 3'd4, 2'd2, 32'hCAFEF00D, 4'd4},  // R4 SP untouched by byte
    {1'b1, 3'd0, 2'd3, 32'hFFFFFFFF, 3'd0, 2'd2, 32'h1122CC99, 4'd7},  // R7 bad view no write
    {1'b0, 3'd0, 2'd2, 32'h00000000, 3'd0, 2'd2, 32'h1122CC99, 4'd10}, // R10 disabled write
    {1'b0, 3'd0, 2'd2, 32'h00000000, 3'd0, 2'd3, 32'h00000000, 4'd8},  // R8 bad read view
    {1'b1, 3'd6, 2'd1, 32'h0000ABCD, 3'd6, 2'd2, 32'h0000ABCD, 4'd2},  // R2 word SI
    {1'b1, 3'd2, 2'd0, 32'h0000005A, 3'd2, 2'd2, 32'h0000005A, 4'd3},  // R3 low byte D
    {1'b0, 3'd0, 2'd2, 32'h00000000, 3'd6, 2'd0, 32'h00000000, 4'd4}   // R4 high byte D
  };

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp,
                       input string what);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL R%0d %s: actual %08h expected %08h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R9 reset state
    for (int i = 0; i < 8; i++) begin
      rda_idx = 3'(i);
      #1 check(9, rda_data, 32'h0, "register clear after reset");
    end
    check(9, {31'b0, wr_err}, 32'h0, "error low after reset");

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      wr_en    = VEC[k][78];
      wr_idx   = VEC[k][77:75];
      wr_width = VEC[k][74:73];
      wr_data  = VEC[k][72:41];
      @(posedge clk);
      #1;
      wr_en     = 1'b0;
      rda_idx   = VEC[k][40:38];
      rda_width = VEC[k][37:36];
      #1 check(int'(VEC[k][3:0]), rda_data, VEC[k][35:4], $sformatf("vector %0d", k));
    end

    // R6 read-before-write on port B, register C still zero
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd1; wr_width = 2'd2; wr_data = 32'h00000055;
    rdb_idx = 3'd1; rdb_width = 2'd2;
    #2 check(6, rdb_data, 32'h0, "old value before edge");
    @(posedge clk);
    #1 wr_en = 1'b0;
    #1 check(6, rdb_data, 32'h00000055, "new value after edge");

    // R5 both ports independent
    rda_idx = 3'd3; rda_width = 2'd1;
    rdb_idx = 3'd7; rdb_width = 2'd0;
    #1 check(5, rda_data, 32'h000077EF, "port A word B");
    check(5, rdb_data, 32'h00000077, "port B high byte B");

    // R7 error pulse timing
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd5; wr_width = 2'd3; wr_data = 32'h12345678;
    @(posedge clk);
    #1 wr_en = 1'b0;
    #1 check(7, {31'b0, wr_err}, 32'h1, "error after bad write");
    @(posedge clk);
    #2 check(7, {31'b0, wr_err}, 32'h0, "error lasts one cycle");
    rda_idx = 3'd5; rda_width = 2'd2;
    #1 check(7, rda_data, 32'h0, "BP unchanged by bad write");

    // R7 back-to-back bad writes keep the flag up
    @(negedge clk);
    wr_en = 1'b1; wr_width = 2'd3;
    @(posedge clk);
    #2 check(7, {31'b0, wr_err}, 32'h1, "first of two bad writes");
    @(posedge clk);
    #1 wr_en = 1'b0;
    #1 check(7, {31'b0, wr_err}, 32'h1, "second of two bad writes");
    @(posedge clk);
    #2 check(7, {31'b0, wr_err}, 32'h0, "flag drops after bad writes");

    // R9 reset clears written registers
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      rda_idx = 3'(i); rda_width = 2'd2;
      #1 check(9, rda_data, 32'h0, "register clear after second reset");
    end

    done = 1'b1;
    finish_run();
  end
endmodule